// File: doc/BRIEF.md
# Address Translation Sequencer with Fault Syndrome

This block sits at the front of a 32-bit memory management unit. It decides how each effective address is translated and, when translation fails, what exception to raise. For every request it works through a fixed priority chain: relocation-off bypass, then a granted block-translation hit reported by a neighbouring matcher, then the segment path. On the segment path, one of sixteen segment registers is selected by the top four address bits. The block then handles direct-store segments, checks segment-level no-execute for fetches, and otherwise hands a page walk to an external walker. It passes the walker a virtual segment ID, a protection key and the no-execute flag.

Each outcome is reported one cycle after it is known, as a one-cycle `done` pulse. A grant comes with a physical address and permissions. A fault comes with an exception class and a syndrome word. Data-side faults also load the fault address register. The controller has two states. In IDLE, a request that needs a page walk takes the transition IDLE->WALK. Any other request is answered at once and stays in IDLE. In WALK, the walker's completion takes the transition WALK->IDLE. While in WALK, further requests are ignored.

Segment register layout: bit 31 direct-store, bit 30 supervisor key, bit 29 user key, bit 28 no-execute, bits 23:0 virtual segment ID. In direct-store segments, bits 28:20 hold a bus-unit ID and bits 3:0 a high address nibble.

Encodings:
- Access kind: 0 load, 1 store, 2 fetch, 3 treated as load.
- Category: 0 integer, 1 float, 2 reservation, 3 cache, 4 external, 5 to 7 invalid.
- Exception class: 0 instruction storage, 1 data storage, 2 alignment, 3 program.
- Permission vector: {execute, write, read}.

Top module: `xlate_seq`

## Requirements
- R1: During and after reset, done, busy and walk_start are 0, and fault_addr and syndrome are 0.
- R2: A fetch with msr_ir=0, or a load or store with msr_dr=0, completes with done=1 and ok=1 in the cycle after the request. It returns pa equal to the effective address and prot=3'b111, whatever blk_hit and the segment registers hold.
- R3: With relocation on and blk_hit=1, the request completes with ok=1, pa=blk_pa and prot=blk_prot, and no walk is started.
- R4: A write with seg_we=1 loads seg_wdata into register seg_widx at the clock edge. A page walk uses the register selected by ea[31:28]. The cycle after the request, walk_start pulses for exactly one cycle and busy=1, with walk_vsid equal to the register's bits 23:0 and walk_nx equal to its bit 28.
- R5: The key is the segment's bit 29 when msr_pr=1 and its bit 30 when msr_pr=0. It is driven on walk_key and also used for direct-store integer accesses.
- R6: A segment with bit 31 set and bits 28:20 equal to 0x07F grants any access, with pa = {seg[3:0], ea[27:0]} and prot=3'b111.
- R7: In any other direct-store segment, the outcome depends on the access:
  - A fetch faults with class 0 and syndrome 0x10000000.
  - A cache access grants pa=ea with prot=3'b011.
  - An integer load grants pa=ea with prot=3'b011 only if the key is 0, and an integer store only if the key is 1. Otherwise it faults with class 1 and syndrome 0x08000000 (load) or 0x0A000000 (store).
  - A float access gives class 2 with syndrome 0.
  - A reservation access gives class 1 with syndrome 0x04000000, or 0x06000000 on a store.
  - An external access gives class 1 with syndrome 0x04100000, or 0x06100000 on a store.
  - Categories 5 to 7 give class 3 with syndrome 0.
- R8: A fetch from a segment with bit 31 clear and bit 28 set faults with class 0 and syndrome 0x10000000, and no walk is started.
- R9: In WALK, walk_done=1 ends the walk, and done follows one cycle later:
  - walk_res=0 grants pa=walk_pa and prot=walk_prot.
  - walk_res=2 is a protection fault.
  - walk_res values 1 and 3 are a not-found fault.
- R10: Instruction-side walk faults use class 0, with syndrome 0x40000000 for not found and 0x08000000 for protection.
- R11: Data-side walk faults use class 1. The syndrome is 0x40000000 for not found and 0x08000000 for protection, each with bit 25 (0x02000000) added on a store.
- R12: fault_addr is loaded with the effective address on every data-side fault (classes 1, 2 and 3). It keeps its value on instruction-side faults and on grants.
- R13: In WALK, req_valid has no effect: there is no done and the walk's result is unchanged. In IDLE, walk_done has no effect and produces no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment register write enable |
| seg_widx | input | 4 | Segment register write index |
| seg_wdata | input | 32 | Segment register write data |
| req_valid | input | 1 | Translation request |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access kind (0 load, 1 store, 2 fetch) |
| req_cat | input | 3 | Access category |
| msr_ir | input | 1 | Instruction relocation enable |
| msr_dr | input | 1 | Data relocation enable |
| msr_pr | input | 1 | User mode |
| blk_hit | input | 1 | Granted block-translation hit |
| blk_pa | input | 32 | Block-translation physical address |
| blk_prot | input | 3 | Block-translation permissions |
| walk_start | output | 1 | Page walk start pulse |
| walk_vsid | output | 24 | Virtual segment ID for the walk |
| walk_key | output | 1 | Protection key for the walk |
| walk_nx | output | 1 | Segment no-execute flag for the walk |
| walk_done | input | 1 | Page walk completion |
| walk_res | input | 2 | Walk result (0 ok, 2 protection, else not found) |
| walk_pa | input | 32 | Walk physical address |
| walk_prot | input | 3 | Walk permissions |
| busy | output | 1 | Waiting on a page walk |
| done | output | 1 | One-cycle result pulse |
| ok | output | 1 | Result is a grant |
| pa | output | 32 | Physical address of the last grant |
| prot | output | 3 | Permissions of the last grant |
| exc | output | 2 | Exception class of the last fault |
| syndrome | output | 32 | Syndrome word of the last fault |
| fault_addr | output | 32 | Effective address of the last data-side fault |

## Verification
A table of single-cycle requests covers these patterns:
- Relocation-off requests with a block hit also present, which shows that bypass ranks above the block hit.
- A block hit with relocation on.
- Forced-I/O segments with fetch and float accesses, which shows that this mapping bypasses the category checks.
- Each category and direction in an ordinary direct-store segment. The same segment word is used in user and supervisor mode, which separates the two key bits.
- A no-execute fetch.

Directed walks then return each walker result for loads, stores and fetches. This separates the instruction-side and data-side syndromes and the store bit. The same walks show that fault_addr moves only on data-side faults. A request sent during a walk, and a completion sent while idle, show that both are ignored.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    localparam int EA_W      = 32;
    localparam int SEG_CNT   = 16;
    localparam int SEG_IDX_W = $clog2(SEG_CNT);
    localparam int VSID_W    = 24;
    localparam int PROT_W    = 3;

    // segment register field positions
    localparam int SEG_T   = 31;
    localparam int SEG_KS  = 30;
    localparam int SEG_KP  = 29;
    localparam int SEG_NX  = 28;
    localparam int BUID_HI = 28;
    localparam int BUID_LO = 20;
    localparam logic [BUID_HI-BUID_LO:0] BUID_FORCED = 9'h07F;

    localparam logic [2:0] CAT_INT   = 3'd0;
    localparam logic [2:0] CAT_FLOAT = 3'd1;
    localparam logic [2:0] CAT_RES   = 3'd2;
    localparam logic [2:0] CAT_CACHE = 3'd3;
    localparam logic [2:0] CAT_EXT   = 3'd4;

    localparam logic [EA_W-1:0] SYN_WRITE = 32'h0200_0000;

    typedef enum logic [1:0] {K_LOAD = 2'd0, K_STORE = 2'd1, K_FETCH = 2'd2, K_RSVD = 2'd3} kind_e;
    typedef enum logic [1:0] {EX_ISI = 2'd0, EX_DSI = 2'd1, EX_ALIGN = 2'd2, EX_PROG = 2'd3} exc_e;
    typedef enum logic [2:0] {C_NONE, C_NOTFOUND, C_PROT, C_NOEXEC, C_DSTORE} cause_e;
    typedef enum logic [1:0] {ACT_GRANT, ACT_FAULT, ACT_WALK} act_e;

    typedef struct packed {
        exc_e            exc;
        logic [EA_W-1:0] syn;
    } fault_t;

    function automatic fault_t encode_fault(cause_e cause, logic is_fetch, logic is_write,
                                            logic [2:0] cat);
        fault_t f;
        logic [EA_W-1:0] wbit;
        wbit  = is_write ? SYN_WRITE : '0;
        f.exc = EX_PROG;
        f.syn = '0;
        if (is_fetch) begin
            f.exc = EX_ISI;
            unique case (cause)
                C_NOTFOUND: f.syn = 32'h4000_0000;
                C_PROT:     f.syn = 32'h0800_0000;
                default:    f.syn = 32'h1000_0000;
            endcase
        end else begin
            unique case (cause)
                C_NOTFOUND: begin f.exc = EX_DSI; f.syn = 32'h4000_0000 | wbit; end
                C_PROT:     begin f.exc = EX_DSI; f.syn = 32'h0800_0000 | wbit; end
                C_DSTORE: begin
                    if (cat == CAT_FLOAT) begin
                        f.exc = EX_ALIGN;
                    end else if (cat == CAT_RES) begin
                        f.exc = EX_DSI; f.syn = 32'h0400_0000 | wbit;
                    end else if (cat == CAT_EXT) begin
                        f.exc = EX_DSI; f.syn = 32'h0410_0000 | wbit;
                    end
                end
                default: f.exc = EX_PROG;
            endcase
        end
        return f;
    endfunction

endpackage

// File: rtl/xlate_segfile.sv
module xlate_segfile
    import xlate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SEG_IDX_W-1:0] widx,
    input  logic [EA_W-1:0]      wdata,
    input  logic [SEG_IDX_W-1:0] ridx,
    output logic [EA_W-1:0]      rdata
);

    logic [SEG_CNT-1:0][EA_W-1:0] regs_all;

    for (genvar i = 0; i < SEG_CNT; i++) begin : g_seg
        logic [EA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (we && widx == SEG_IDX_W'(i))
                q <= wdata;
        end
        assign regs_all[i] = q;
    end

    assign rdata = regs_all[ridx];

endmodule

// File: rtl/xlate_decide.sv
module xlate_decide
    import xlate_pkg::*;
(
    input  logic [EA_W-1:0]   ea,
    input  kind_e             kind,
    input  logic [2:0]        cat,
    input  logic              msr_ir,
    input  logic              msr_dr,
    input  logic              msr_pr,
    input  logic              blk_hit,
    input  logic [EA_W-1:0]   blk_pa,
    input  logic [PROT_W-1:0] blk_prot,
    input  logic [EA_W-1:0]   seg,
    output act_e              act,
    output cause_e            cause,
    output logic [EA_W-1:0]   pa,
    output logic [PROT_W-1:0] prot,
    output logic              key,
    output logic              nx
);

    logic fetch, real_mode, forced_io;

    always_comb begin
        fetch     = (kind == K_FETCH);
        real_mode = fetch ? !msr_ir : !msr_dr;
        forced_io = (seg[BUID_HI:BUID_LO] == BUID_FORCED);
        key       = msr_pr ? seg[SEG_KP] : seg[SEG_KS];
        nx        = seg[SEG_NX];
        act       = ACT_WALK;
        cause     = C_NONE;
        pa        = ea;
        prot      = '0;
        if (real_mode) begin
            act  = ACT_GRANT;
            prot = 3'b111;
        end else if (blk_hit) begin
            act  = ACT_GRANT;
            pa   = blk_pa;
            prot = blk_prot;
        end else if (seg[SEG_T]) begin
            if (forced_io) begin
                act  = ACT_GRANT;
                pa   = {seg[3:0], ea[EA_W-5:0]};
                prot = 3'b111;
            end else if (fetch) begin
                act   = ACT_FAULT;
                cause = C_DSTORE;
            end else if (cat == CAT_CACHE) begin
                act  = ACT_GRANT;
                prot = 3'b011;
            end else if (cat == CAT_INT) begin
                if ((kind == K_STORE) ? key : !key) begin
                    act  = ACT_GRANT;
                    prot = 3'b011;
                end else begin
                    act   = ACT_FAULT;
                    cause = C_PROT;
                end
            end else begin
                act   = ACT_FAULT;
                cause = C_DSTORE;
            end
        end else if (fetch && seg[SEG_NX]) begin
            act   = ACT_FAULT;
            cause = C_NOEXEC;
        end

        if (fetch && msr_ir && !blk_hit && !seg[SEG_T] && seg[SEG_NX]) begin
            AST_NX_NO_WALK: assert (act == ACT_FAULT && cause == C_NOEXEC); // R8
        end
    end

endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
    import xlate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seg_we,
    input  logic [SEG_IDX_W-1:0] seg_widx,
    input  logic [EA_W-1:0]      seg_wdata,
    input  logic                 req_valid,
    input  logic [EA_W-1:0]      req_ea,
    input  logic [1:0]           req_kind,
    input  logic [2:0]           req_cat,
    input  logic                 msr_ir,
    input  logic                 msr_dr,
    input  logic                 msr_pr,
    input  logic                 blk_hit,
    input  logic [EA_W-1:0]      blk_pa,
    input  logic [PROT_W-1:0]    blk_prot,
    output logic                 walk_start,
    output logic [VSID_W-1:0]    walk_vsid,
    output logic                 walk_key,
    output logic                 walk_nx,
    input  logic                 walk_done,
    input  logic [1:0]           walk_res,
    input  logic [EA_W-1:0]      walk_pa,
    input  logic [PROT_W-1:0]    walk_prot,
    output logic                 busy,
    output logic                 done,
    output logic                 ok,
    output logic [EA_W-1:0]      pa,
    output logic [PROT_W-1:0]    prot,
    output logic [1:0]           exc,
    output logic [EA_W-1:0]      syndrome,
    output logic [EA_W-1:0]      fault_addr
);

    typedef enum logic {ST_IDLE, ST_WALK} state_e;
    state_e state_q, state_d;

    logic [EA_W-1:0]   seg_word, dec_pa;
    act_e              dec_act;
    cause_e            dec_cause;
    logic [PROT_W-1:0] dec_prot;
    logic              dec_key, dec_nx;

    xlate_segfile u_seg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seg_we),
        .widx  (seg_widx),
        .wdata (seg_wdata),
        .ridx  (req_ea[EA_W-1 -: SEG_IDX_W]),
        .rdata (seg_word)
    );

    xlate_decide u_dec (
        .ea       (req_ea),
        .kind     (kind_e'(req_kind)),
        .cat      (req_cat),
        .msr_ir   (msr_ir),
        .msr_dr   (msr_dr),
        .msr_pr   (msr_pr),
        .blk_hit  (blk_hit),
        .blk_pa   (blk_pa),
        .blk_prot (blk_prot),
        .seg      (seg_word),
        .act      (dec_act),
        .cause    (dec_cause),
        .pa       (dec_pa),
        .prot     (dec_prot),
        .key      (dec_key),
        .nx       (dec_nx)
    );

    logic [EA_W-1:0] ea_q;
    kind_e           kind_q;
    logic [2:0]      cat_q;

    logic              go_walk, fin_valid, fin_ok;
    logic [EA_W-1:0]   fin_pa, fin_ea;
    logic [PROT_W-1:0] fin_prot;
    cause_e            fin_cause;
    kind_e             fin_kind;
    logic [2:0]        fin_cat;
    fault_t            fin_flt;

    // next state and the result being finished this cycle
    always_comb begin
        go_walk   = 1'b0;
        fin_valid = 1'b0;
        fin_ok    = 1'b0;
        fin_pa    = dec_pa;
        fin_prot  = dec_prot;
        fin_cause = dec_cause;
        fin_kind  = kind_e'(req_kind);
        fin_cat   = req_cat;
        fin_ea    = req_ea;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dec_act == ACT_WALK) begin
                        go_walk = 1'b1;
                        state_d = ST_WALK;
                    end else begin
                        fin_valid = 1'b1;
                        fin_ok    = (dec_act == ACT_GRANT);
                    end
                end
            end
            ST_WALK: begin
                if (walk_done) begin
                    fin_valid = 1'b1;
                    fin_ok    = (walk_res == 2'd0);
                    fin_pa    = walk_pa;
                    fin_prot  = walk_prot;
                    fin_cause = (walk_res == 2'd2) ? C_PROT : C_NOTFOUND;
                    fin_kind  = kind_q;
                    fin_cat   = cat_q;
                    fin_ea    = ea_q;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        fin_flt = encode_fault(fin_cause, fin_kind == K_FETCH, fin_kind == K_STORE, fin_cat);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_start <= 1'b0;
            walk_vsid  <= '0;
            walk_key   <= 1'b0;
            walk_nx    <= 1'b0;
            done       <= 1'b0;
            ok         <= 1'b0;
            pa         <= '0;
            prot       <= '0;
            exc        <= '0;
            syndrome   <= '0;
            fault_addr <= '0;
            ea_q       <= '0;
            kind_q     <= K_LOAD;
            cat_q      <= '0;
        end else begin
            walk_start <= go_walk;
            done       <= fin_valid;
            if (go_walk) begin
                walk_vsid <= seg_word[VSID_W-1:0];
                walk_key  <= dec_key;
                walk_nx   <= dec_nx;
                ea_q      <= req_ea;
                kind_q    <= kind_e'(req_kind);
                cat_q     <= req_cat;
            end
            if (fin_valid) begin
                ok <= fin_ok;
                if (fin_ok) begin
                    pa   <= fin_pa;
                    prot <= fin_prot;
                end else begin
                    exc      <= fin_flt.exc;
                    syndrome <= fin_flt.syn;
                    if (fin_kind != K_FETCH)
                        fault_addr <= fin_ea;
                end
            end
        end
    end

    assign busy = (state_q == ST_WALK);

    AST_WALK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |=> !walk_start); // R4

    AST_REAL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid &&
         ((req_kind == 2'd2) ? !msr_ir : !msr_dr))
        |=> (done && ok && pa == $past(req_ea) && prot == 3'b111)); // R2

    AST_ISI_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok && exc == 2'd0) |-> ($countones(syndrome) == 1)); // R10

    AST_ISI_KEEPS_FA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (ok || exc == 2'd0)) |-> $stable(fault_addr)); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !req_valid) |=> !done); // R13

endmodule

// File: tb/sim_xlate_seq.sv
module sim_xlate_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [3:0]  seg_widx = '0;
    logic [31:0] seg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_cat = '0;
    logic        msr_ir = 1'b1, msr_dr = 1'b1, msr_pr = 1'b0;
    logic        blk_hit = 1'b0;
    logic [31:0] blk_pa = 32'h00AB_C000;
    logic [2:0]  blk_prot = 3'b101;
    logic        walk_start, walk_key, walk_nx;
    logic [23:0] walk_vsid;
    logic        walk_done = 1'b0;
    logic [1:0]  walk_res = '0;
    logic [31:0] walk_pa = '0;
    logic [2:0]  walk_prot = '0;
    logic        busy, done, ok;
    logic [31:0] pa, syndrome, fault_addr;
    logic [2:0]  prot;
    logic [1:0]  exc;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    xlate_seq u0 (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_widx(seg_widx), .seg_wdata(seg_wdata),
        .req_valid(req_valid), .req_ea(req_ea), .req_kind(req_kind), .req_cat(req_cat),
        .msr_ir(msr_ir), .msr_dr(msr_dr), .msr_pr(msr_pr),
        .blk_hit(blk_hit), .blk_pa(blk_pa), .blk_prot(blk_prot),
        .walk_start(walk_start), .walk_vsid(walk_vsid), .walk_key(walk_key), .walk_nx(walk_nx),
        .walk_done(walk_done), .walk_res(walk_res), .walk_pa(walk_pa), .walk_prot(walk_prot),
        .busy(busy), .done(done), .ok(ok), .pa(pa), .prot(prot), .exc(exc),
        .syndrome(syndrome), .fault_addr(fault_addr)
    );

    typedef struct packed {
        logic [31:0] seg;
        logic [31:0] ea;
        logic [1:0]  kind;
        logic [2:0]  cat;
        logic        ir, dr, pr, bh, eok;
        logic [31:0] epa;
        logic [2:0]  eprot;
        logic [1:0]  eexc;
        logic [31:0] esyn;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        // R2 fetch, relocation off, block hit present
        {32'h0, 32'h1234_5678, 2'd2, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h1234_5678, 3'd7, 2'd0, 32'h0, 8'd2},
        // R2 store, data relocation off
        {32'h0, 32'h9000_0004, 2'd1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h9000_0004, 3'd7, 2'd0, 32'h0, 8'd2},
        // R3 block hit
        {32'h0, 32'h2000_1000, 2'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h00AB_C000, 3'd5, 2'd0, 32'h0, 8'd3},
        // R6 forced I/O fetch
        {32'h87F0_0005, 32'h3123_4567, 2'd2, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h5123_4567, 3'd7, 2'd0, 32'h0, 8'd6},
        // R6 forced I/O float store
        {32'h87F0_0005, 32'h3000_0040, 2'd1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h5000_0040, 3'd7, 2'd0, 32'h0, 8'd6},
        // R7 fetch from direct-store
        {32'h8000_0000, 32'h4000_0000, 2'd2, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 3'd0, 2'd0, 32'h1000_0000, 8'd7},
        // R7 cache op passes
        {32'h8000_0000, 32'h4000_0010, 2'd0, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h4000_0010, 3'd3, 2'd0, 32'h0, 8'd7},
        // R7 integer load key 0
        {32'h8000_0000, 32'h4000_0020, 2'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h4000_0020, 3'd3, 2'd0, 32'h0, 8'd7},
        // R7 integer store key 0 denied
        {32'h8000_0000, 32'h4000_0030, 2'd1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 3'd0, 2'd1, 32'h0A00_0000, 8'd7},
        // R5 user store, user key 1
        {32'hA000_0000, 32'h5000_0000, 2'd1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h5000_0000, 3'd3, 2'd0, 32'h0, 8'd5},
        // R5 user load, user key 1 denied
        {32'hA000_0000, 32'h5000_0004, 2'd0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 3'd0, 2'd1, 32'h0800_0000, 8'd5},
        // R5 supervisor load, supervisor key 0
        {32'hA000_0000, 32'h5000_0008, 2'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h5000_0008, 3'd3, 2'd0, 32'h0, 8'd5},
        // R7 float
        {32'h8000_0000, 32'h4000_0040, 2'd1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 3'd0, 2'd2, 32'h0, 8'd7},
        // R7 reservation load / store
        {32'h8000_0000, 32'h4000_0050, 2'd0, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 3'd0, 2'd1, 32'h0400_0000, 8'd7},
        {32'h8000_0000, 32'h4000_0054, 2'd1, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 3'd0, 2'd1, 32'h0600_0000, 8'd7},
        // R7 external load / store
        {32'h8000_0000, 32'h4000_0058, 2'd0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 3'd0, 2'd1, 32'h0410_0000, 8'd7},
        {32'h8000_0000, 32'h4000_005C, 2'd1, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 3'd0, 2'd1, 32'h0610_0000, 8'd7},
        // R8 no-execute fetch
        {32'h1000_0000, 32'h7000_0000, 2'd2, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 3'd0, 2'd0, 32'h1000_0000, 8'd8}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic seg_write(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        seg_we = 1'b1; seg_widx = idx; seg_wdata = val;
        @(posedge clk);
        @(negedge clk);
        seg_we = 1'b0;
    endtask

    task automatic do_req(input logic [31:0] ea, input logic [1:0] kind, input logic [2:0] cat);
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_kind = kind; req_cat = cat;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic walk_finish(input logic [1:0] res, input logic [31:0] wpa, input logic [2:0] wprot);
        walk_done = 1'b1; walk_res = res; walk_pa = wpa; walk_prot = wprot;
        @(posedge clk);
        @(negedge clk);
        walk_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 walk_start", {31'd0, walk_start}, 32'd0);
        check("R1 fault_addr", fault_addr, 32'd0);
        check("R1 syndrome", syndrome, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = TBL[i];
            t = $sformatf("R%0d row%0d", v.rq, i);
            seg_write(v.ea[31:28], v.seg);
            msr_ir = v.ir; msr_dr = v.dr; msr_pr = v.pr; blk_hit = v.bh;
            do_req(v.ea, v.kind, v.cat);
            check({t, " done"}, {31'd0, done}, 32'd1);
            check({t, " ok"}, {31'd0, ok}, {31'd0, v.eok});
            check({t, " walk_start"}, {31'd0, walk_start}, 32'd0);
            if (v.eok) begin
                check({t, " pa"}, pa, v.epa);
                check({t, " prot"}, {29'd0, prot}, {29'd0, v.eprot});
            end else begin
                check({t, " exc"}, {30'd0, exc}, {30'd0, v.eexc});
                check({t, " syn"}, syndrome, v.esyn);
                if (v.eexc != 2'd0) check({t, " fault_addr R12"}, fault_addr, v.ea);
            end
        end
        msr_ir = 1'b1; msr_dr = 1'b1; msr_pr = 1'b0; blk_hit = 1'b0;

        // R4 R5 R9 walk grant, supervisor key
        seg_write(4'd6, 32'h40AB_CDEF);
        do_req(32'h6000_2000, 2'd0, 3'd0);
        check("R4 walk_start", {31'd0, walk_start}, 32'd1);
        check("R4 busy", {31'd0, busy}, 32'd1);
        check("R4 vsid", {8'd0, walk_vsid}, 32'h00AB_CDEF);
        check("R5 key sup", {31'd0, walk_key}, 32'd1);
        check("R4 nx", {31'd0, walk_nx}, 32'd0);
        check("R4 done low", {31'd0, done}, 32'd0);
        walk_finish(2'd0, 32'h7770_0000, 3'b011);
        check("R9 done", {31'd0, done}, 32'd1);
        check("R9 ok", {31'd0, ok}, 32'd1);
        check("R9 pa", pa, 32'h7770_0000);
        check("R9 prot", {29'd0, prot}, 32'd3);
        check("R9 busy", {31'd0, busy}, 32'd0);

        // R5 R11 R12 user store not found
        msr_pr = 1'b1;
        do_req(32'h6000_3000, 2'd1, 3'd0);
        check("R5 key user", {31'd0, walk_key}, 32'd0);
        walk_finish(2'd1, 32'h0, 3'd0);
        msr_pr = 1'b0;
        check("R11 store nf exc", {30'd0, exc}, 32'd1);
        check("R11 store nf syn", syndrome, 32'h4200_0000);
        check("R12 fault_addr", fault_addr, 32'h6000_3000);

        // R10 R12 fetch protection
        do_req(32'h6000_4000, 2'd2, 3'd0);
        walk_finish(2'd2, 32'h0, 3'd0);
        check("R10 fetch prot exc", {30'd0, exc}, 32'd0);
        check("R10 fetch prot syn", syndrome, 32'h0800_0000);
        check("R12 kept on ISI", fault_addr, 32'h6000_3000);

        // R10 fetch not found
        do_req(32'h6000_5000, 2'd2, 3'd0);
        walk_finish(2'd1, 32'h0, 3'd0);
        check("R10 fetch nf syn", syndrome, 32'h4000_0000);

        // R11 load / store protection
        do_req(32'h6000_6000, 2'd0, 3'd0);
        walk_finish(2'd2, 32'h0, 3'd0);
        check("R11 load prot syn", syndrome, 32'h0800_0000);
        do_req(32'h6000_7000, 2'd1, 3'd0);
        walk_finish(2'd2, 32'h0, 3'd0);
        check("R11 store prot syn", syndrome, 32'h0A00_0000);
        check("R12 fault_addr 2", fault_addr, 32'h6000_7000);

        // R9 result code 3 is not found; R12 kept on grant afterwards
        do_req(32'h6000_8000, 2'd0, 3'd0);
        walk_finish(2'd3, 32'h0, 3'd0);
        check("R9 res3 ok", {31'd0, ok}, 32'd0);
        check("R9 res3 syn", syndrome, 32'h4000_0000);
        do_req(32'h6000_9000, 2'd0, 3'd0);
        walk_finish(2'd0, 32'h1234_0000, 3'd1);
        check("R12 kept on grant", fault_addr, 32'h6000_8000);

        // R8 R4 data access in no-execute segment still walks
        seg_write(4'd7, 32'h1000_0055);
        do_req(32'h7000_0000, 2'd0, 3'd0);
        check("R8 data walks", {31'd0, walk_start}, 32'd1);
        check("R4 nx out", {31'd0, walk_nx}, 32'd1);
        check("R4 vsid 2", {8'd0, walk_vsid}, 32'h0000_0055);
        walk_finish(2'd0, 32'h0, 3'd0);

        // R4 overwrite of a segment register
        seg_write(4'd6, 32'h0012_3456);
        do_req(32'h6000_0000, 2'd0, 3'd0);
        check("R4 rewrite vsid", {8'd0, walk_vsid}, 32'h0012_3456);
        check("R5 key rewrite", {31'd0, walk_key}, 32'd0);

        // R13 request during walk ignored
        req_valid = 1'b1; req_ea = 32'h1111_1110; req_kind = 2'd2; msr_ir = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; msr_ir = 1'b1;
        check("R13 no done in walk", {31'd0, done}, 32'd0);
        check("R13 still busy", {31'd0, busy}, 32'd1);
        walk_finish(2'd0, 32'h7770_1000, 3'd1);
        check("R13 walk result", pa, 32'h7770_1000);
        check("R13 one done", {31'd0, done}, 32'd1);
        @(negedge clk);
        check("R13 done pulse", {31'd0, done}, 32'd0);

        // R13 completion while idle ignored
        walk_finish(2'd0, 32'hDEAD_0000, 3'd7);
        check("R13 idle walk_done", {31'd0, done}, 32'd0);
        check("R13 idle pa", pa, 32'h7770_1000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule